// File: doc/BRIEF.md
# Transport Packet Checksum Sync Encoder

This block turns a serial stream of fixed-length 188-byte transport packets into a stream in which the constant sync byte no longer appears. In its place goes an 8-bit parity checksum over the 187 bytes that came before it. Bits arrive one per beat, MSB first, on a valid/ready interface, with a start strobe on the first bit of each sync byte. The block drops the incoming sync byte and passes the 1496 payload bits straight through with no register in the path. It then inserts eight checksum bits, MSB first, and withholds input ready while it does so.

The checksum comes from a division shift register with the divisor g(X) = 1 + X + X^5 + X^6 + X^8. This register is cleared when each packet starts. It is fed the payload bits and then eight zero bits, and the quotient bits produced during those eight zero shifts form the syndrome. The syndrome goes through a feed-forward filter with the same polynomial g, whose history is also cleared when the packet starts. The constant 0x67 is then added to the result. A receiver that runs the matching parity check over the 187 bytes and the checksum byte is meant to find 0x47 for an intact word. That receiver, its sliding search and packet error flagging belong to other blocks.

Top module: `pkt_cks_encoder`

## Requirements
- R1: After reset, and while no packet is under way, in_ready is 1 and out_valid is 0.
- R2: While hunting, input beats without in_sop are consumed and produce no output.
- R3: A beat with in_sop=1 seen while hunting is the first of 8 sync-byte bits. All 8 are consumed and none reaches the output.
- R4: The next 1496 accepted bits appear unchanged on out_data in the cycle they are offered. In this phase out_valid equals in_valid and in_ready equals out_ready.
- R5: Directly after the 1496th payload bit, 8 checksum bits are emitted MSB first, with in_ready held at 0. The byte is Z XOR 0x67. Y is the quotient of the payload followed by 8 zeros divided by g (taps at lags 1, 5, 6 and 8). Z is the last 8 bits of Y, each XORed with the earlier ones of those 8 bits at lags 1, 5 and 6. An all-zero payload therefore gives 0x67.
- R6: Both shift registers are cleared at each packet start, so a packet's checksum depends only on its own payload.
- R7: While out_ready is 0 during the checksum, out_valid stays 1 and out_data does not change.
- R8: in_sop is ignored on every beat outside the hunting phase; such beats are treated as ordinary data.
- R9: After the 8th checksum bit the block returns to hunting, so the next packet needs a fresh in_sop.
- R10: A synchronous reset in mid-packet abandons that packet and returns the block to the hunting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Block accepts the input bit |
| in_data | input | 1 | Input bit, MSB first |
| in_sop | input | 1 | Marks the first bit of a packet's sync byte |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Sink accepts the output bit |
| out_data | output | 1 | Output bit: payload or checksum |

## Verification
A wrong tap or a missed clear in either shift register leaves the payload untouched. It shows only in the checksum bits that follow the 1496th payload bit, typically in several of the eight, so the bench compares every checksum byte against an independent bit-serial model. A sequencing fault shows up sooner. An off-by-one in the sync or payload count shifts every later output bit by one position, and a missed return to hunting makes stray bits appear after the checksum. Both break the first following packet's payload comparison, well before its checksum.

// File: rtl/pkt_cks_pkg.sv
package pkt_cks_pkg;
  typedef enum logic [1:0] {PH_HUNT, PH_SYNC, PH_PAY, PH_CKS} phase_t;
  // g(X) = X^8 + X^6 + X^5 + X + 1, bit k holds the X^k coefficient
  localparam logic [8:0] G_POLY_DEF = 9'h163;
  localparam logic [7:0] CKS_OFFSET_DEF = 8'h67;
endpackage

// File: rtl/pkt_cks_shift_filter.sv
// One shift register with polynomial taps. RECURSIVE=1: divider (history
// holds the outputs). RECURSIVE=0: feed-forward filter (history holds inputs).
module pkt_cks_shift_filter #(
  parameter int          W         = 8,
  parameter logic [W-1:0] TAPS     = 8'hB1,
  parameter bit          RECURSIVE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic din,
  output logic dout
);
  logic [W-1:0] hist;
  logic         shift_in;

  assign dout = din ^ (^(hist & TAPS));

  generate
    if (RECURSIVE) begin : g_iir
      assign shift_in = dout;
    end else begin : g_fir
      assign shift_in = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) hist <= '0;
    else if (step)  hist <= {hist[W-2:0], shift_in};
  end

  // R6: history empty on the cycle after a packet start
  a_r6_hist_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hist == '0));
endmodule

// File: rtl/pkt_cks_seq.sv
module pkt_cks_seq
  import pkt_cks_pkg::*;
#(
  parameter int SYNC_BITS = 8,
  parameter int PAY_BITS  = 1496,
  parameter int CKS_BITS  = 8,
  localparam int CW = $clog2(PAY_BITS),
  localparam int IW = $clog2(CKS_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          pay_ph,
  output logic          cks_ph,
  output logic [IW-1:0] cks_idx,
  output logic          clr,
  output logic          div_step,
  output logic          fir_step
);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_BITS - 1);
  localparam logic [CW-1:0] PAY_LAST  = CW'(PAY_BITS - 1);
  localparam logic [CW-1:0] CKS_LAST  = CW'(CKS_BITS - 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          in_fire, out_fire;

  always_comb begin
    pay_ph    = (ph == PH_PAY);
    cks_ph    = (ph == PH_CKS);
    in_ready  = (ph == PH_HUNT) || (ph == PH_SYNC) || (pay_ph && out_ready);
    out_valid = (pay_ph && in_valid) || cks_ph;
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    clr       = (ph == PH_HUNT) && in_fire && in_sop;
    div_step  = (pay_ph && in_fire) || (cks_ph && out_fire);
    fir_step  = cks_ph && out_fire;
    cks_idx   = cnt[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_HUNT;
      cnt <= '0;
    end else begin
      case (ph)
        PH_HUNT: if (clr) begin
          ph  <= PH_SYNC;
          cnt <= CW'(1);
        end
        PH_SYNC: if (in_fire) begin
          if (cnt == SYNC_LAST) begin ph <= PH_PAY; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_PAY: if (in_fire) begin
          if (cnt == PAY_LAST) begin ph <= PH_CKS; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: if (out_fire) begin
          if (cnt == CKS_LAST) begin ph <= PH_HUNT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R4: payload counter never passes the payload length
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PAY) |-> (cnt < CW'(PAY_BITS)));
  // R5: the checksum index stays inside the checksum byte
  a_r5_cks_range: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_CKS) |-> (cnt < CW'(CKS_BITS)));
endmodule

// File: rtl/pkt_cks_encoder.sv
module pkt_cks_encoder
  import pkt_cks_pkg::*;
#(
  parameter int          SYNC_BITS = 8,
  parameter int          PAY_BITS  = 1496,
  parameter int          CKS_BITS  = 8,
  parameter logic [8:0]  G_POLY    = G_POLY_DEF,
  parameter logic [7:0]  OFFSET    = CKS_OFFSET_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_data,
  input  logic in_sop,
  output logic out_valid,
  input  logic out_ready,
  output logic out_data
);
  localparam int IW = $clog2(CKS_BITS);
  localparam logic [CKS_BITS-1:0] TAPS = G_POLY[CKS_BITS:1];

  logic          pay_ph, cks_ph, clr, div_step, fir_step;
  logic [IW-1:0] cks_idx;
  logic          div_in, quot, filt;
  logic [CKS_BITS-1:0] off_rev;

  pkt_cks_seq #(.SYNC_BITS(SYNC_BITS), .PAY_BITS(PAY_BITS), .CKS_BITS(CKS_BITS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .pay_ph(pay_ph), .cks_ph(cks_ph),
    .cks_idx(cks_idx), .clr(clr), .div_step(div_step), .fir_step(fir_step));

  assign div_in = pay_ph & in_data;

  pkt_cks_shift_filter #(.W(CKS_BITS), .TAPS(TAPS), .RECURSIVE(1'b1)) u_div (
    .clk(clk), .rst(rst), .clr(clr), .step(div_step), .din(div_in), .dout(quot));

  pkt_cks_shift_filter #(.W(CKS_BITS), .TAPS(TAPS), .RECURSIVE(1'b0)) u_fir (
    .clk(clk), .rst(rst), .clr(clr), .step(fir_step), .din(quot), .dout(filt));

  always_comb begin
    for (int i = 0; i < CKS_BITS; i++) off_rev[i] = OFFSET[CKS_BITS-1-i];
    out_data = pay_ph ? in_data : (filt ^ off_rev[cks_idx]);
  end

  // R1: the cycle after reset the block hunts
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));
  // R7: a stalled checksum bit is held
  a_r7_cks_hold: assert property (@(posedge clk) disable iff (rst)
    (cks_ph && !out_ready) |=> (out_valid && !in_ready && $stable(out_data)));
endmodule

// File: tb/tb_pkt_cks_encoder.sv
module tb_pkt_cks_encoder;
  localparam int PB = 1496;
  localparam int MAXB = 16384;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_data = 1'b0, in_sop = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_data;

  pkt_cks_encoder dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit sin_d [0:MAXB-1]; bit sin_s [0:MAXB-1];
  bit exp_o [0:MAXB-1]; bit got_o [0:MAXB-1];
  int n_in, n_exp, n_pkt, op;
  int pstart [0:15]; logic [7:0] pcks [0:15];
  bit pay [0:PB-1]; bit saved [0:PB-1];
  logic [7:0] first_cks;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
      finish_run();
    end
  end

  function automatic logic [7:0] ref_cks();
    bit y [0:PB+7];
    logic [7:0] r;
    for (int n = 0; n < PB + 8; n++) begin
      bit a = (n < PB) ? pay[n] : 1'b0;
      if (n >= 1) a ^= y[n-1];
      if (n >= 5) a ^= y[n-5];
      if (n >= 6) a ^= y[n-6];
      if (n >= 8) a ^= y[n-8];
      y[n] = a;
    end
    for (int k = 0; k < 8; k++) begin
      bit z = y[PB+k];
      if (k >= 1) z ^= y[PB+k-1];
      if (k >= 5) z ^= y[PB+k-5];
      if (k >= 6) z ^= y[PB+k-6];
      r[7-k] = z ^ ((8'h67 >> (7-k)) & 1);
    end
    return r;
  endfunction

  task automatic clear_stream();
    n_in = 0; n_exp = 0; n_pkt = 0;
  endtask

  task automatic add_junk(input int n);
    for (int i = 0; i < n; i++) begin
      sin_d[n_in] = 1'($urandom); sin_s[n_in] = 1'b0; n_in++;
    end
  endtask

  // mode 0 zeros, 1 ones, 2 random, 3 replay saved; sop_noise marks payload beats with sop
  task automatic add_packet(input int mode, input bit sop_noise);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      sin_d[n_in] = 1'((8'h47 >> (7-i)) & 1); sin_s[n_in] = (i == 0); n_in++;
    end
    for (int i = 0; i < PB; i++) begin
      case (mode)
        0: pay[i] = 1'b0;
        1: pay[i] = 1'b1;
        2: pay[i] = 1'($urandom);
        default: pay[i] = saved[i];
      endcase
      sin_d[n_in] = pay[i];
      sin_s[n_in] = sop_noise && ($urandom % 50 == 0);
      n_in++;
    end
    c = ref_cks();
    pstart[n_pkt] = n_exp; pcks[n_pkt] = c; n_pkt++;
    for (int i = 0; i < PB; i++) begin exp_o[n_exp] = pay[i]; n_exp++; end
    for (int i = 0; i < 8; i++) begin exp_o[n_exp] = c[7-i]; n_exp++; end
  endtask

  task automatic run(input int vprob, input int rprob);
    int ip = 0, tcount = 0, tail = 0;
    op = 0;
    while (tail < 20) begin
      @(negedge clk);
      in_valid  = (ip < n_in) && (($urandom % 100) < vprob);
      in_data   = (ip < n_in) ? sin_d[ip] : 1'b0;
      in_sop    = (ip < n_in) ? sin_s[ip] : 1'b0;
      out_ready = (($urandom % 100) < rprob) || (ip >= n_in);
      #2;
      if (in_valid && in_ready) ip++;
      if (out_valid && out_ready) begin
        if (op < MAXB) got_o[op] = out_data;
        op++;
      end
      if (ip >= n_in && op >= n_exp) tail++;
      tcount++;
      if (tcount > 60000) begin
        chk(1'b0, "R4 run timeout", op, n_exp);
        tail = 20;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; out_ready = 1'b0;
  endtask

  task automatic compare(input string tag);
    chk(op == n_exp, {"R3/R9 output count ", tag}, op, n_exp);
    for (int p = 0; p < n_pkt; p++) begin
      int mism = 0;
      logic [7:0] g;
      for (int i = 0; i < PB; i++)
        if (got_o[pstart[p]+i] != exp_o[pstart[p]+i]) mism++;
      chk(mism == 0, {"R4 payload pass-through ", tag}, mism, 0);
      for (int i = 0; i < 8; i++) g[7-i] = got_o[pstart[p]+PB+i];
      chk(g == pcks[p], {"R5 checksum ", tag}, g, pcks[p]);
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 2'b10);

    // all-zero payload: checksum is the bare offset
    clear_stream(); add_packet(0, 1'b0); run(100, 100); compare("zeros");
    chk(pcks[0] == 8'h67, "R5 zero payload gives 0x67", pcks[0], 8'h67);

    // junk before sop, then all-ones packet
    clear_stream(); add_junk(13); add_packet(1, 1'b0); run(100, 100);
    compare("R2 junk then ones");

    // random packets, random flow control, third replays the first
    clear_stream();
    add_packet(2, 1'b0);
    for (int i = 0; i < PB; i++) saved[i] = pay[i];
    first_cks = pcks[0];
    add_junk(5); add_packet(2, 1'b0); add_junk(3); add_packet(3, 1'b0);
    run(70, 60); compare("R7 random backpressure");
    chk(pcks[2] == first_cks && pcks[1] != first_cks, "R6 clear per packet",
        pcks[2], first_cks);

    // R8: sop strobes inside payload ignored
    clear_stream(); add_packet(2, 1'b1); add_packet(2, 1'b1); run(85, 75);
    compare("R8 stray sop");

    // R9: after checksum, data without sop is dropped
    clear_stream(); add_junk(40); run(100, 100);
    chk(op == 0, "R9 hunt after checksum", op, 0);

    // R10: reset mid-payload
    clear_stream(); add_packet(2, 1'b0);
    n_in = 8 + 700; n_exp = 700; n_pkt = 0;
    run(100, 100);
    chk(op == 700, "R10 partial payload out", op, 700);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; #2;
    chk(in_ready && !out_valid, "R10 reset mid-packet", {in_ready, out_valid}, 2'b10);
    clear_stream(); add_packet(2, 1'b0); run(90, 90); compare("R10 after reset");

    finish_run();
  end
endmodule